// File: doc/BRIEF.md
# Hardware Thread Select Unit

This unit sits at the front of a single scalar pipeline and keeps the fetch context of several hardware threads: one program counter per thread and a small state for each (off, ready, or waiting on memory). In every clock cycle it chooses one ready thread and presents that thread's PC with the thread's tag and a valid bit. Later pipeline stages use the tag to tell apart the instructions of different threads. The issued thread's PC then steps forward by one instruction word.

Two scheduling policies can be selected at any time through a mode input. In interleaved mode the issuing thread rotates every cycle. In blocked mode one thread keeps the pipeline until the memory side reports a long-latency access for it. Either way, a tagged stall event parks the thread, and a tagged completion for that thread makes it eligible again. The thread resumes from the PC it held when it was parked. When some other thread is ready, a switch away from a parked thread costs no idle cycle.

Top module: `thr_issue_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every thread is off and `fetch_vld` is 0.
- R2: A `start_req[i]` pulse on an off thread i makes it ready at `start_pc[i*PC_W +: PC_W]`. The pulse is ignored while thread i is ready or waiting.
- R3: A fetch shows the chosen thread's index on `fetch_tag` (binary thread number) and that thread's current PC on `fetch_pc`. Each issued fetch advances that thread's PC by 4.
- R4: When `mode_blocked` is 0, the thread chosen is the first ready thread in increasing index order, wrapping around, starting after the thread issued most recently. When more than one thread is ready, two consecutive fetches never carry the same tag.
- R5: When `mode_blocked` is 1, the thread issued most recently keeps issuing for as long as it stays ready. Only when it is not ready is the round-robin choice of R4 used.
- R6: `stall_vld` with `stall_tag` naming a ready thread makes that thread wait from the next cycle on. If any other thread is ready, that next cycle issues one of them, so no bubble is added. A stall that names an off thread has no effect.
- R7: `done_vld` with `done_tag` naming a waiting thread makes it ready again, and its next fetch uses the PC it held while it waited.
- R8: A completion that names a thread that is not waiting is ignored. A stall and a completion for the same thread in the same cycle leave that thread waiting.
- R9: When no thread is ready, `fetch_vld` is 0 and no PC changes.
- R10: `redir_vld` overwrites the PC of thread `redir_tag` with `redir_pc` if that thread is ready or waiting, and this takes priority over the increment of R3. A redirect aimed at an off thread is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| mode_blocked | input | 1 | 1 = blocked scheduling, 0 = interleaved scheduling |
| start_req | input | N_THR | Per-thread start pulse |
| start_pc | input | N_THR*PC_W | Start PC of each thread, thread i at bits i*PC_W upward |
| stall_vld | input | 1 | Long-latency event for one thread |
| stall_tag | input | TAG_W | Thread named by the stall event |
| done_vld | input | 1 | Completion of a long-latency access |
| done_tag | input | TAG_W | Thread named by the completion |
| redir_vld | input | 1 | PC overwrite request |
| redir_tag | input | TAG_W | Thread whose PC is overwritten |
| redir_pc | input | PC_W | New PC value |
| fetch_vld | output | 1 | A fetch is issued this cycle |
| fetch_tag | output | TAG_W | Thread of the issued fetch |
| fetch_pc | output | PC_W | PC of the issued fetch |

## Verification
The properties assume that at most one stall, one completion and one redirect arrive per cycle, and that each tag is below N_THR. They also assume that the stall, completion, redirect and start inputs are stable around the clock edge. The bench respects these limits by changing inputs only on the falling edge, by using tags 0 to 3 with the default of four threads, and by using one shared valid/tag pair per event kind. It also waits out the two-cycle reset release before it sends the first start request, so no start request is lost while the internal reset is still held.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    TH_OFF  = 2'd0,
    TH_RDY  = 2'd1,
    TH_WAIT = 2'd2
  } th_state_e;
endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/thr_ctx.sv
module thr_ctx #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_hit,
  input  logic [PC_W-1:0] start_pc,
  input  logic            stall_hit,
  input  logic            done_hit,
  input  logic            redir_hit,
  input  logic [PC_W-1:0] redir_pc,
  input  logic            issue_hit,
  output logic            ready,
  output logic            waiting,
  output logic [PC_W-1:0] pc
);
  import thr_pkg::*;

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  th_state_e       st_q, st_d;
  logic [PC_W-1:0] pc_d;
  logic            pc_en;

  // next state of the thread
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TH_OFF:  if (start_hit) st_d = TH_RDY;
      TH_RDY:  if (stall_hit) st_d = TH_WAIT;
      TH_WAIT: if (done_hit && !stall_hit) st_d = TH_RDY;
      default: st_d = TH_OFF;
    endcase
  end

  // next PC: start load, redirect over increment
  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc;
    if (st_q == TH_OFF) begin
      if (start_hit) begin
        pc_en = 1'b1;
        pc_d  = start_pc;
      end
    end else if (redir_hit) begin
      pc_en = 1'b1;
      pc_d  = redir_pc;
    end else if (issue_hit) begin
      pc_en = 1'b1;
      pc_d  = pc + PC_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TH_OFF;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= '0;
    else if (pc_en) pc <= pc_d;
  end

  assign ready   = (st_q == TH_RDY);
  assign waiting = (st_q == TH_WAIT);
endmodule

// File: rtl/thr_rr_pick.sv
module thr_rr_pick #(
  parameter int N_THR = 4,
  localparam int TAG_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic [N_THR-1:0] ready,
  input  logic [TAG_W-1:0] last_tag,
  input  logic             hold,
  output logic             pick_vld,
  output logic [TAG_W-1:0] pick_tag
);
  int               idx;
  logic [TAG_W-1:0] cand;
  logic             found;

  always_comb begin
    pick_vld = |ready;
    pick_tag = last_tag;
    found    = 1'b0;
    idx      = 0;
    cand     = '0;
    if (hold && ready[last_tag]) begin
      found = 1'b1;
    end
    for (int k = 1; k <= N_THR; k++) begin
      idx  = (int'(last_tag) + k) % N_THR;
      cand = TAG_W'(idx);
      if (!found && ready[cand]) begin
        found    = 1'b1;
        pick_tag = cand;
      end
    end
  end
endmodule

// File: rtl/thr_issue_sel.sv
module thr_issue_sel #(
  parameter int N_THR = 4,
  parameter int PC_W  = 32,
  localparam int TAG_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_blocked,
  input  logic [N_THR-1:0]      start_req,
  input  logic [N_THR*PC_W-1:0] start_pc,
  input  logic                  stall_vld,
  input  logic [TAG_W-1:0]      stall_tag,
  input  logic                  done_vld,
  input  logic [TAG_W-1:0]      done_tag,
  input  logic                  redir_vld,
  input  logic [TAG_W-1:0]      redir_tag,
  input  logic [PC_W-1:0]       redir_pc,
  output logic                  fetch_vld,
  output logic [TAG_W-1:0]      fetch_tag,
  output logic [PC_W-1:0]       fetch_pc
);
  logic                  rst_q_n;
  logic [N_THR-1:0]      ready_vec;
  logic [N_THR-1:0]      wait_vec;
  logic [N_THR*PC_W-1:0] pc_flat;
  logic [TAG_W-1:0]      last_q;
  logic                  pick_vld;
  logic [TAG_W-1:0]      pick_tag;

  thr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    logic hit_stall, hit_done, hit_redir, hit_issue;
    assign hit_stall = stall_vld && (stall_tag == TAG_W'(g));
    assign hit_done  = done_vld  && (done_tag  == TAG_W'(g));
    assign hit_redir = redir_vld && (redir_tag == TAG_W'(g));
    assign hit_issue = pick_vld  && (pick_tag  == TAG_W'(g));

    thr_ctx #(.PC_W(PC_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .start_hit (start_req[g]),
      .start_pc  (start_pc[g*PC_W +: PC_W]),
      .stall_hit (hit_stall),
      .done_hit  (hit_done),
      .redir_hit (hit_redir),
      .redir_pc  (redir_pc),
      .issue_hit (hit_issue),
      .ready     (ready_vec[g]),
      .waiting   (wait_vec[g]),
      .pc        (pc_flat[g*PC_W +: PC_W])
    );
  end

  thr_rr_pick #(.N_THR(N_THR)) u_pick (
    .ready    (ready_vec),
    .last_tag (last_q),
    .hold     (mode_blocked),
    .pick_vld (pick_vld),
    .pick_tag (pick_tag)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      last_q <= '0;
    else if (pick_vld) last_q <= pick_tag;
  end

  assign fetch_vld = pick_vld;
  assign fetch_tag = pick_tag;
  assign fetch_pc  = pc_flat[int'(pick_tag)*PC_W +: PC_W];
endmodule

// File: rtl/thr_issue_sel_chk.sv
module thr_issue_sel_chk #(
  parameter int N_THR = 4,
  parameter int PC_W  = 32,
  localparam int TAG_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_blocked,
  input logic [N_THR-1:0]      start_req,
  input logic                  stall_vld,
  input logic [TAG_W-1:0]      stall_tag,
  input logic                  done_vld,
  input logic [TAG_W-1:0]      done_tag,
  input logic                  redir_vld,
  input logic [TAG_W-1:0]      redir_tag,
  input logic                  fetch_vld,
  input logic [TAG_W-1:0]      fetch_tag,
  input logic [PC_W-1:0]       fetch_pc,
  input logic [N_THR-1:0]      ready_vec,
  input logic [N_THR-1:0]      wait_vec,
  input logic [N_THR*PC_W-1:0] pc_flat
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> !fetch_vld && ready_vec == '0);

  assert_tag_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> ready_vec[fetch_tag]);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && !(redir_vld && redir_tag == fetch_tag)
    |=> pc_flat[int'($past(fetch_tag))*PC_W +: PC_W] == $past(fetch_pc) + PC_W'(4));

  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_blocked && fetch_vld && $past(!mode_blocked && fetch_vld)
    && $countones(ready_vec) > 1 |-> fetch_tag != $past(fetch_tag));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_blocked && $past(mode_blocked && fetch_vld) && ready_vec[$past(fetch_tag)]
    |-> fetch_vld && fetch_tag == $past(fetch_tag));

  assert_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_vld && ready_vec[stall_tag] |=> wait_vec[$past(stall_tag)]);

  assert_no_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready_vec) |-> fetch_vld);

  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && wait_vec[done_tag] && !(stall_vld && stall_tag == done_tag)
    |=> ready_vec[$past(done_tag)]);

  assert_stray_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && !wait_vec[done_tag] && !(stall_vld && stall_tag == done_tag)
    |=> !wait_vec[$past(done_tag)]);

  assert_tie_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && stall_vld && done_tag == stall_tag && wait_vec[done_tag]
    |=> wait_vec[$past(done_tag)]);

  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld && !redir_vld && start_req == '0 |=> $stable(pc_flat));
endmodule

bind thr_issue_sel thr_issue_sel_chk #(.N_THR(N_THR), .PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .mode_blocked (mode_blocked),
  .start_req    (start_req),
  .stall_vld    (stall_vld),
  .stall_tag    (stall_tag),
  .done_vld     (done_vld),
  .done_tag     (done_tag),
  .redir_vld    (redir_vld),
  .redir_tag    (redir_tag),
  .fetch_vld    (fetch_vld),
  .fetch_tag    (fetch_tag),
  .fetch_pc     (fetch_pc),
  .ready_vec    (ready_vec),
  .wait_vec     (wait_vec),
  .pc_flat      (pc_flat)
);

// File: tb/thr_issue_sel_bench.sv
module thr_issue_sel_bench;
  localparam int N = 4;
  localparam int W = 32;

  logic          clk;
  logic          rst_n;
  logic          mode_blocked;
  logic [N-1:0]  start_req;
  logic [N*W-1:0] start_pc;
  logic          stall_vld, done_vld, redir_vld;
  logic [1:0]    stall_tag, done_tag, redir_tag;
  logic [W-1:0]  redir_pc;
  logic          fetch_vld;
  logic [1:0]    fetch_tag;
  logic [W-1:0]  fetch_pc;

  int n_chk = 0;
  int n_bad = 0;

  thr_issue_sel #(.N_THR(N), .PC_W(W)) u_thr_issue_sel (
    .clk(clk), .rst_n(rst_n), .mode_blocked(mode_blocked),
    .start_req(start_req), .start_pc(start_pc),
    .stall_vld(stall_vld), .stall_tag(stall_tag),
    .done_vld(done_vld), .done_tag(done_tag),
    .redir_vld(redir_vld), .redir_tag(redir_tag), .redir_pc(redir_pc),
    .fetch_vld(fetch_vld), .fetch_tag(fetch_tag), .fetch_pc(fetch_pc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic       md;
    logic [3:0] st;
    logic       sv;
    logic [1:0] stg;
    logic       dv;
    logic [1:0] dtg;
    logic       ev;
    logic [1:0] et;
    logic [31:0] ep;
    logic [3:0] rq;
  } vec_t;

  // thread i starts at 0x100*(i+1); expected fetch is the one shown before the edge
  localparam vec_t TBL [24] = '{
    '{1'b0, 4'hF, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 32'h000, 4'd2},  // R2 all start
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 32'h200, 4'd4},  // R4 after 0 -> 1
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 32'h300, 4'd4},
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 32'h400, 4'd4},
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 32'h100, 4'd4},  // R4 wrap
    '{1'b0, 4'h0, 1'b1, 2'd2, 1'b0, 2'd0, 1'b1, 2'd1, 32'h204, 4'd3},  // R3 step, stall T2
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 32'h404, 4'd6},  // R6 T2 skipped
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 2'd0, 32'h104, 4'd8},  // R8 stray done T1
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 2'd1, 32'h208, 4'd8},  // done T2
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 32'h304, 4'd7},  // R7 resume PC
    '{1'b1, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2, 32'h308, 4'd5},  // R5 hold T2
    '{1'b1, 4'h0, 1'b1, 2'd2, 1'b0, 2'd0, 1'b1, 2'd2, 32'h30C, 4'd5},  // stall T2
    '{1'b1, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 32'h408, 4'd6},  // R6 no bubble
    '{1'b1, 4'h0, 1'b1, 2'd3, 1'b1, 2'd2, 1'b1, 2'd3, 32'h40C, 4'd5},
    '{1'b1, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 32'h108, 4'd6},
    '{1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 2'd0, 1'b1, 2'd0, 32'h10C, 4'd8},  // R8 tie on ready
    '{1'b1, 4'h0, 1'b1, 2'd1, 1'b0, 2'd0, 1'b1, 2'd1, 32'h20C, 4'd8},  // T0 stays parked
    '{1'b1, 4'h0, 1'b1, 2'd2, 1'b0, 2'd0, 1'b1, 2'd2, 32'h310, 4'd5},
    '{1'b1, 4'h0, 1'b1, 2'd2, 1'b1, 2'd2, 1'b0, 2'd0, 32'h000, 4'd9},  // R9, R8 tie on waiting
    '{1'b1, 4'h0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0, 32'h000, 4'd9},  // T2 still parked
    '{1'b1, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 32'h210, 4'd7},
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1, 2'd1, 32'h214, 4'd4},  // lone ready repeats
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0, 32'h110, 4'd7},
    '{1'b0, 4'h0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 32'h218, 4'd4}
  };

  task automatic idle_inputs();
    start_req = '0;
    stall_vld = 1'b0; stall_tag = '0;
    done_vld  = 1'b0; done_tag  = '0;
    redir_vld = 1'b0; redir_tag = '0; redir_pc = '0;
  endtask

  task automatic check(input logic ev, input logic [1:0] et, input logic [31:0] ep,
                       input string rq);
    n_chk++;
    if (fetch_vld !== ev || (ev && (fetch_tag !== et || fetch_pc !== ep))) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b tag=%0d pc=%h, expected vld=%0b tag=%0d pc=%h",
               rq, fetch_vld, fetch_tag, fetch_pc, ev, et, ep);
    end
  endtask

  task automatic cyc(input logic md, input logic [3:0] st,
                     input logic sv, input logic [1:0] stg,
                     input logic dv, input logic [1:0] dtg,
                     input logic rv, input logic [1:0] rtg, input logic [31:0] rpc,
                     input logic ev, input logic [1:0] et, input logic [31:0] ep,
                     input string rq);
    @(negedge clk);
    mode_blocked = md; start_req = st;
    stall_vld = sv; stall_tag = stg;
    done_vld = dv;  done_tag = dtg;
    redir_vld = rv; redir_tag = rtg; redir_pc = rpc;
    #1;
    check(ev, et, ep, rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check(1'b0, 2'd0, 32'h0, "R1 during reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(1'b0, 2'd0, 32'h0, "R1 after reset");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got no end, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode_blocked = 1'b0;
    idle_inputs();
    for (int i = 0; i < N; i++) start_pc[i*W +: W] = 32'(32'h100 * (i + 1));
    do_reset();

    for (int v = 0; v < 24; v++) begin
      cyc(TBL[v].md, TBL[v].st, TBL[v].sv, TBL[v].stg, TBL[v].dv, TBL[v].dtg,
          1'b0, 2'd0, 32'h0, TBL[v].ev, TBL[v].et, TBL[v].ep,
          $sformatf("R%0d vector %0d", TBL[v].rq, v));
    end

    // R1: reset in mid-run clears every thread
    do_reset();

    // R2: start on an off thread, then a second start on it is ignored
    cyc(0, 4'b0100, 0, 0, 0, 0, 0, 0, 0,        0, 0, 32'h000, "R2 start T2");
    cyc(0, 4'b0100, 0, 0, 0, 0, 0, 0, 0,        1, 2, 32'h300, "R2 start PC");
    cyc(0, 4'b0000, 0, 0, 0, 0, 1, 2, 32'h800,  1, 2, 32'h304, "R2 restart ignored");
    // R10: redirect beats increment; redirect and stall aimed at off T3 ignored
    cyc(0, 4'b0000, 1, 3, 0, 0, 1, 3, 32'h900,  1, 2, 32'h800, "R10 redirect taken");
    cyc(0, 4'b1000, 0, 0, 0, 0, 0, 0, 0,        1, 2, 32'h804, "R10 after redirect");
    cyc(0, 4'b0000, 0, 0, 0, 0, 0, 0, 0,        1, 3, 32'h400, "R10 off-thread redirect ignored, R6 stall on off ignored");
    // R9: all parked, PCs frozen over idle cycles
    cyc(0, 4'b0000, 1, 2, 0, 0, 0, 0, 0,        1, 2, 32'h808, "R4 wrap to T2");
    cyc(0, 4'b0000, 1, 3, 0, 0, 0, 0, 0,        1, 3, 32'h404, "R6 switch to T3");
    cyc(0, 4'b0000, 0, 0, 0, 0, 0, 0, 0,        0, 0, 32'h000, "R9 idle");
    cyc(0, 4'b0000, 0, 0, 1, 3, 0, 0, 0,        0, 0, 32'h000, "R9 idle");
    cyc(0, 4'b0000, 0, 0, 0, 0, 0, 0, 0,        1, 3, 32'h408, "R9 PC kept, R7 wake");
    @(negedge clk);
    idle_inputs();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule